// File: doc/BRIEF.md
# Bit-Addressed Interrupt Control Register

This block is an eight-bit control and status register. It sits between a local I/O processor and a host system bus. Each register bit has its own address inside an aligned window of eight local addresses. When the local processor touches a bit's address, by a read or by a write, that bit goes to its inactive value on the next clock. Hardware events on the host side set the bits that carry interrupts and the bus-lock flag.

The block drives four status outputs:
- an active-low interrupt request toward the host;
- two interrupt lines toward the local processor, one for attention and one for the queue;
- a bus-locked flag that keeps the local processor off the shared dual-port memory;
- a one-clock, active-low loopback strobe.

A local read of any address in the window returns all eight bits. The value returned is the one held before the clear that the read causes.

Top module: `bitreg_irq_ctrl`

## Requirements
- R1: A local access reaches the register only when `loc_cs` is high and `loc_addr` bits above bit 2 equal those of `BASE`. The offset `loc_addr[2:0]` = k then selects bit k. An access at any other offset, or outside the window, leaves bit k unchanged.
- R2: While `rst` is high, and on the clock after it, `host_irq_n` is 1 and `loopback_n` is 1. At the same points `bus_locked`, `loc_irq1` and `loc_irq0` are 0.
- R3: Bit 7 is the active-low host request and drives `host_irq_n`. A local write to offset 7 with `loc_wd7` = 0 drives it to 0 on the next clock. Any other access to offset 7 drives it to 1: a read, or a write with `loc_wd7` = 1.
- R4: `host_ack` high drives bit 7 to 1 on the next clock. This holds even when a firmware write that would assert bit 7 arrives on the same clock.
- R5: `mem_delay` high sets bit 6 on the next clock. `bus_locked` always shows bit 6.
- R6: An access to offset 6 clears bit 6 on the next clock. If `dummy_pend` is high on that clock, bit 6 keeps its value.
- R7: An access to offset 5 drives `loopback_n` low for exactly the one following clock. Bits 2 to 5 always read as 0.
- R8: `host_reg_acc` high sets bit 1 (`loc_irq1`). A local access to offset 1 clears it.
- R9: `host_vec_acc` high while `host_iack` is low sets bit 0 (`loc_irq0`). With `host_iack` high, `host_vec_acc` has no effect. A local access to offset 0 clears bit 0.
- R10: When a hardware set event and a local clear access hit bit 0, bit 1 or bit 6 on the same clock, the bit ends up set.
- R11: During a local read inside the window, `rd_data[k]` equals bit k as it was before the read's clear. At all other times `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_cs | input | 1 | Local access strobe |
| loc_we | input | 1 | Local access is a write (1) or a read (0) |
| loc_addr | input | ADDR_W | Local I/O address |
| loc_wd7 | input | 1 | Local write data line at bit position 7 |
| host_reg_acc | input | 1 | Host accessed this register |
| host_vec_acc | input | 1 | Host accessed the ID/vector register |
| host_iack | input | 1 | The host access is an interrupt acknowledge cycle |
| host_ack | input | 1 | Host acknowledged the host interrupt request |
| mem_delay | input | 1 | Local shared-memory access was delayed |
| dummy_pend | input | 1 | A dummy read is pending; blocks the bit 6 clear |
| rd_data | output | 8 | Register readback |
| host_irq_n | output | 1 | Active-low interrupt request to the host |
| bus_locked | output | 1 | Local access to the shared memory is blocked |
| loc_irq1 | output | 1 | Attention interrupt to the local processor |
| loc_irq0 | output | 1 | Queue interrupt to the local processor |
| loopback_n | output | 1 | Active-low loopback strobe |

## Verification
The per-bit set/clear function is driven from a vector table with several patterns:
- a single set event alone, which separates each bit's set path from its neighbours';
- a single clear access alone, which separates the clear paths;
- set and clear on the same clock, which shows which of the two has priority;
- the two blocking qualifiers, `host_iack` and `dummy_pend`, which separate a qualified event from a plain one.

Writes to offset 7 with either data value separate firmware assertion from negation. The acknowledge arriving together with an assert shows which one dominates.

Directed tests cover the rest:
- out-of-window accesses and accesses with the strobe low, which must leave state unchanged;
- the loopback strobe's width of one clock;
- readback before and after a read's own clear.

// File: rtl/bitreg_irq_pkg.sv
package bitreg_irq_pkg;

    localparam int NBITS = 8;
    localparam int OFF_W = $clog2(NBITS);

    // bit roles; the offset of each inside the window is its index
    localparam int B_QIRQ = 0;
    localparam int B_ATTN = 1;
    localparam int B_LOOP = 5;
    localparam int B_LOCK = 6;
    localparam int B_HREQ = 7;

    typedef enum logic [1:0] {
        K_PLAIN,
        K_EVENT,
        K_LOCK,
        K_HREQ
    } bit_kind_t;

    typedef struct packed {
        logic reg_acc;
        logic vec_acc;
        logic iack;
        logic ack;
        logic mem_delay;
        logic dummy_pend;
    } host_ev_t;

    function automatic bit_kind_t kind_of(int idx);
        if (idx == B_HREQ)                      return K_HREQ;
        else if (idx == B_LOCK)                 return K_LOCK;
        else if (idx == B_ATTN || idx == B_QIRQ) return K_EVENT;
        else                                    return K_PLAIN;
    endfunction

    function automatic logic rst_val_of(int idx);
        return (idx == B_HREQ) ? 1'b1 : 1'b0;
    endfunction

endpackage

// File: rtl/bitreg_decode.sv
module bitreg_decode
    import bitreg_irq_pkg::*;
#(
    parameter int                ADDR_W = 8,
    parameter logic [ADDR_W-1:0] BASE   = 8'h40
) (
    input  logic              loc_cs,
    input  logic [ADDR_W-1:0] loc_addr,
    output logic [NBITS-1:0]  hit
);
    localparam int HI = ADDR_W - 1;

    logic in_win;

    always_comb begin
        in_win = loc_cs && (loc_addr[HI:OFF_W] == BASE[HI:OFF_W]);
        hit    = '0;
        if (in_win) hit[loc_addr[OFF_W-1:0]] = 1'b1;
    end
endmodule

// File: rtl/bitreg_cell.sv
module bitreg_cell #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic hw_ev,
    input  logic hw_val,
    input  logic acc,
    input  logic acc_val,
    input  logic acc_hold,
    output logic q
);
    // a hardware event outranks a local access on the same clock
    always_ff @(posedge clk) begin
        if (rst)                    q <= RST_VAL;
        else if (hw_ev)             q <= hw_val;
        else if (acc && !acc_hold)  q <= acc_val;
    end
endmodule

// File: rtl/bitreg_irq_ctrl.sv
module bitreg_irq_ctrl
    import bitreg_irq_pkg::*;
#(
    parameter int                ADDR_W = 8,
    parameter logic [ADDR_W-1:0] BASE   = 8'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              loc_cs,
    input  logic              loc_we,
    input  logic [ADDR_W-1:0] loc_addr,
    input  logic              loc_wd7,
    input  logic              host_reg_acc,
    input  logic              host_vec_acc,
    input  logic              host_iack,
    input  logic              host_ack,
    input  logic              mem_delay,
    input  logic              dummy_pend,
    output logic [NBITS-1:0]  rd_data,
    output logic              host_irq_n,
    output logic              bus_locked,
    output logic              loc_irq1,
    output logic              loc_irq0,
    output logic              loopback_n
);
    host_ev_t         ev;
    logic [NBITS-1:0] hit;
    logic [NBITS-1:0] q;
    logic [NBITS-1:0] hw_ev;
    logic [NBITS-1:0] hw_val;
    logic [NBITS-1:0] acc_val;
    logic [NBITS-1:0] acc_hold;
    logic             lb_q;

    assign ev = '{reg_acc:    host_reg_acc,
                  vec_acc:    host_vec_acc,
                  iack:       host_iack,
                  ack:        host_ack,
                  mem_delay:  mem_delay,
                  dummy_pend: dummy_pend};

    bitreg_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
        .loc_cs   (loc_cs),
        .loc_addr (loc_addr),
        .hit      (hit)
    );

    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        localparam bit_kind_t KIND = kind_of(i);

        if (KIND == K_HREQ) begin : g_hreq
            // firmware asserts with data 0; any other access negates
            assign hw_ev[i]    = ev.ack;
            assign hw_val[i]   = 1'b1;
            assign acc_val[i]  = ~loc_we | loc_wd7;
            assign acc_hold[i] = 1'b0;
        end else if (KIND == K_LOCK) begin : g_lock
            assign hw_ev[i]    = ev.mem_delay;
            assign hw_val[i]   = 1'b1;
            assign acc_val[i]  = 1'b0;
            assign acc_hold[i] = ev.dummy_pend;
        end else if (KIND == K_EVENT) begin : g_evt
            if (i == B_ATTN) begin : g_attn
                assign hw_ev[i] = ev.reg_acc;
            end else begin : g_queue
                assign hw_ev[i] = ev.vec_acc & ~ev.iack;
            end
            assign hw_val[i]   = 1'b1;
            assign acc_val[i]  = 1'b0;
            assign acc_hold[i] = 1'b0;
        end else begin : g_plain
            assign hw_ev[i]    = 1'b0;
            assign hw_val[i]   = 1'b0;
            assign acc_val[i]  = 1'b0;
            assign acc_hold[i] = 1'b0;
        end

        bitreg_cell #(.RST_VAL(rst_val_of(i))) u_cell (
            .clk      (clk),
            .rst      (rst),
            .hw_ev    (hw_ev[i]),
            .hw_val   (hw_val[i]),
            .acc      (hit[i]),
            .acc_val  (acc_val[i]),
            .acc_hold (acc_hold[i]),
            .q        (q[i])
        );
    end

    // one-clock low strobe after an access to the loopback offset
    always_ff @(posedge clk) begin
        if (rst) lb_q <= 1'b1;
        else     lb_q <= ~hit[B_LOOP];
    end

    assign rd_data    = (!loc_we && (|hit)) ? q : '0;
    assign host_irq_n = q[B_HREQ];
    assign bus_locked = q[B_LOCK];
    assign loc_irq1   = q[B_ATTN];
    assign loc_irq0   = q[B_QIRQ];
    assign loopback_n = lb_q;

endmodule

// File: rtl/bitreg_irq_ctrl_chk.sv
module bitreg_irq_ctrl_chk #(
    parameter int                ADDR_W = 8,
    parameter logic [ADDR_W-1:0] BASE   = 8'h40
) (
    input logic              clk,
    input logic              rst,
    input logic              loc_cs,
    input logic              loc_we,
    input logic [ADDR_W-1:0] loc_addr,
    input logic              loc_wd7,
    input logic              host_reg_acc,
    input logic              host_vec_acc,
    input logic              host_iack,
    input logic              host_ack,
    input logic              mem_delay,
    input logic              dummy_pend,
    input logic              host_irq_n,
    input logic              bus_locked,
    input logic              loc_irq1,
    input logic              loc_irq0,
    input logic              loopback_n
);
    logic in_win;
    assign in_win = loc_cs && (loc_addr[ADDR_W-1:3] == BASE[ADDR_W-1:3]);

    // R2
    rst_state_chk: assert property (@(posedge clk)
        rst |=> (host_irq_n && loopback_n && !bus_locked && !loc_irq1 && !loc_irq0));

    // R3
    fw_assert_chk: assert property (@(posedge clk) disable iff (rst)
        (in_win && loc_we && loc_addr[2:0] == 3'd7 && !loc_wd7 && !host_ack) |=> !host_irq_n);

    // R4
    host_ack_chk: assert property (@(posedge clk) disable iff (rst)
        host_ack |=> host_irq_n);

    // R5
    lock_set_chk: assert property (@(posedge clk) disable iff (rst)
        mem_delay |=> bus_locked);

    // R6
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (in_win && loc_addr[2:0] == 3'd6 && dummy_pend && bus_locked) |=> bus_locked);

    // R7
    loop_low_chk: assert property (@(posedge clk) disable iff (rst)
        (in_win && loc_addr[2:0] == 3'd5) |=> !loopback_n);

    // R7
    loop_high_chk: assert property (@(posedge clk) disable iff (rst)
        !(in_win && loc_addr[2:0] == 3'd5) |=> loopback_n);

    // R8
    attn_set_chk: assert property (@(posedge clk) disable iff (rst)
        host_reg_acc |=> loc_irq1);

    // R9
    queue_set_chk: assert property (@(posedge clk) disable iff (rst)
        (host_vec_acc && !host_iack) |=> loc_irq0);
endmodule

bind bitreg_irq_ctrl bitreg_irq_ctrl_chk #(.ADDR_W(ADDR_W), .BASE(BASE)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .loc_cs       (loc_cs),
    .loc_we       (loc_we),
    .loc_addr     (loc_addr),
    .loc_wd7      (loc_wd7),
    .host_reg_acc (host_reg_acc),
    .host_vec_acc (host_vec_acc),
    .host_iack    (host_iack),
    .host_ack     (host_ack),
    .mem_delay    (mem_delay),
    .dummy_pend   (dummy_pend),
    .host_irq_n   (host_irq_n),
    .bus_locked   (bus_locked),
    .loc_irq1     (loc_irq1),
    .loc_irq0     (loc_irq0),
    .loopback_n   (loopback_n)
);

// File: tb/bitreg_irq_ctrl_bench.sv
module bitreg_irq_ctrl_bench;
    localparam int         ADDR_W = 8;
    localparam logic [7:0] BASE   = 8'h40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       loc_cs = 0, loc_we = 0, loc_wd7 = 0;
    logic [7:0] loc_addr = '0;
    logic       host_reg_acc = 0, host_vec_acc = 0, host_iack = 0;
    logic       host_ack = 0, mem_delay = 0, dummy_pend = 0;
    logic [7:0] rd_data;
    logic       host_irq_n, bus_locked, loc_irq1, loc_irq0, loopback_n;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    bitreg_irq_ctrl #(.ADDR_W(ADDR_W), .BASE(BASE)) u_bitreg_irq_ctrl (
        .clk(clk), .rst(rst), .loc_cs(loc_cs), .loc_we(loc_we),
        .loc_addr(loc_addr), .loc_wd7(loc_wd7),
        .host_reg_acc(host_reg_acc), .host_vec_acc(host_vec_acc),
        .host_iack(host_iack), .host_ack(host_ack),
        .mem_delay(mem_delay), .dummy_pend(dummy_pend),
        .rd_data(rd_data), .host_irq_n(host_irq_n), .bus_locked(bus_locked),
        .loc_irq1(loc_irq1), .loc_irq0(loc_irq0), .loopback_n(loopback_n)
    );

    typedef struct packed {
        logic       cs;
        logic       we;
        logic [2:0] off;
        logic       wd;
        logic       hreg;
        logic       hvec;
        logic       iack;
        logic       ack;
        logic       mdly;
        logic       dpend;
        logic [3:0] exp;   // {host_irq_n, bus_locked, loc_irq1, loc_irq0}
        logic [3:0] req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        //  cs    we    off   wd    hreg  hvec  iack  ack   mdly  dpnd  exp      req
        '{1'b0,1'b0,3'd0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,4'b1010,4'd8 },  // R8 set
        '{1'b0,1'b0,3'd0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,4'b1010,4'd9 },  // R9 iack blocks
        '{1'b0,1'b0,3'd0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,4'b1011,4'd9 },  // R9 set
        '{1'b1,1'b1,3'd0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'b1010,4'd9 },  // R9 clear by write
        '{1'b1,1'b0,3'd1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,4'b1010,4'd10},  // R10 set wins
        '{1'b1,1'b0,3'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'b1000,4'd8 },  // R8 clear by read
        '{1'b0,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,4'b1100,4'd5 },  // R5 lock set
        '{1'b1,1'b0,3'd6,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,4'b1100,4'd6 },  // R6 dummy holds
        '{1'b1,1'b0,3'd6,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'b1000,4'd6 },  // R6 clear
        '{1'b1,1'b1,3'd7,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'b0000,4'd3 },  // R3 assert
        '{1'b1,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'b0000,4'd1 },  // R1 other offset
        '{1'b0,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,4'b1000,4'd4 },  // R4 ack
        '{1'b1,1'b1,3'd7,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'b0000,4'd3 },  // R3 assert
        '{1'b1,1'b1,3'd7,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'b1000,4'd3 },  // R3 write 1 negates
        '{1'b1,1'b1,3'd7,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,4'b1000,4'd4 },  // R4 ack beats assert
        '{1'b1,1'b1,3'd6,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,4'b1100,4'd10},  // R10 lock set wins
        '{1'b1,1'b0,3'd6,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'b1000,4'd6 }   // R6 clear
    };

    task automatic check(input string req, input string what,
                         input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic idle();
        loc_cs = 0; loc_we = 0; loc_addr = BASE; loc_wd7 = 0;
        host_reg_acc = 0; host_vec_acc = 0; host_iack = 0;
        host_ack = 0; mem_delay = 0; dummy_pend = 0;
    endtask

    function automatic logic [7:0] st4();
        return {4'b0, host_irq_n, bus_locked, loc_irq1, loc_irq0};
    endfunction

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        // R2 state during and right after reset
        check("R2", "state in reset", st4(), 8'h08);
        check("R2", "loopback in reset", {7'b0, loopback_n}, 8'h01);
        rst = 0;
        @(negedge clk);
        check("R2", "state after reset", st4(), 8'h08);
        check("R11", "rd_data idle", rd_data, 8'h00);

        for (int i = 0; i < NV; i++) begin
            loc_cs = VECS[i].cs; loc_we = VECS[i].we;
            loc_addr = BASE | {5'b0, VECS[i].off}; loc_wd7 = VECS[i].wd;
            host_reg_acc = VECS[i].hreg; host_vec_acc = VECS[i].hvec;
            host_iack = VECS[i].iack; host_ack = VECS[i].ack;
            mem_delay = VECS[i].mdly; dummy_pend = VECS[i].dpend;
            @(negedge clk);
            check($sformatf("R%0d", VECS[i].req), $sformatf("vector %0d", i),
                  st4(), {4'b0, VECS[i].exp});
        end
        idle();
        @(negedge clk);

        // R7 loopback strobe one clock wide
        loc_cs = 1; loc_addr = BASE | 8'd5;
        @(negedge clk);
        idle();
        check("R7", "loopback low", {7'b0, loopback_n}, 8'h00);
        @(negedge clk);
        check("R7", "loopback back high", {7'b0, loopback_n}, 8'h01);

        // R11 readback before and after the read's own clear
        host_reg_acc = 1;
        @(negedge clk);
        idle();
        loc_cs = 1; loc_we = 0; loc_addr = BASE | 8'd1;
        #1;
        check("R11", "read pre-clear", rd_data, 8'h82);
        @(negedge clk);
        check("R11", "read post-clear", rd_data, 8'h80);
        loc_we = 1; loc_wd7 = 1;
        #1;
        check("R11", "rd_data on write", rd_data, 8'h00);
        @(negedge clk);

        // R1 out-of-window and deselected accesses leave bit 0 alone
        idle();
        host_vec_acc = 1;
        @(negedge clk);
        idle();
        loc_cs = 1; loc_we = 1; loc_addr = BASE + 8'd8;
        @(negedge clk);
        check("R1", "out of window", st4(), 8'h09);
        loc_cs = 0; loc_addr = BASE;
        @(negedge clk);
        check("R1", "cs low", st4(), 8'h09);
        loc_cs = 1; loc_we = 0;
        #1;
        check("R7", "bits 2..5 read zero", rd_data & 8'h3C, 8'h00);
        @(negedge clk);
        idle();
        check("R9", "offset 0 read clears", st4(), 8'h08);

        // R2 reset mid-run restores defaults
        loc_cs = 1; loc_we = 1; loc_addr = BASE | 8'd7; loc_wd7 = 0;
        @(negedge clk);
        idle();
        mem_delay = 1;
        @(negedge clk);
        idle();
        rst = 1;
        @(negedge clk);
        rst = 0;
        check("R2", "mid-run reset", st4(), 8'h08);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule